// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block is the per-chunk control engine placed between a descriptor-driven DMA channel and an IDE drive. A start command arms it with the byte count of the whole command: the sector count times 512 for a disk, or a packet byte count for an optical drive. The block then kicks the channel. Each time the channel offers a chunk (a length), the sequencer decides what to do with it. It may ask the channel to wait because the command is not armed yet. It may finish the IDE command, or end only the current DMA chunk. Otherwise it issues a read, write or trim request, with the absolute byte offset, to the downstream aligner.

When the aligner reports completion, the sequencer ends the chunk. It raises the ready status and the interrupt once the running byte count has been consumed. It reports a DMA error if the aligner flags one. An optical command that is not block-based is served as a direct copy, bounded by the remaining count. The interrupt is a level that the host clears by reading the status byte.

Top module: `ide_xfer_seq`

## Requirements
- R1: After reset, status_o is 0x00, and irq_o, active_o and every pulse output are 0.
- R2: One cycle after start_i, kick_o pulses, active_o is 1 and status_o is 0x80 (busy, bit 7). The byte count loads as nsect_i*512 when optical_i is 0, or as pkt_bytes_i when it is 1, and the index is cleared.
- R3: A chunk offered while active_o is 0 produces a one-cycle wait_o pulse. It produces no chunk_end_o and no request.
- R4: For a disk, a chunk with nonzero length issues req_o one cycle later with req_off_o = cur_sector_i*512 + index and req_len_o = the chunk length. cmd_i selects req_kind_o: 0 read, 1 write, 2 trim. Each issued request advances the index and reduces the count by its length.
- R5: For an optical drive with block_i = 1, req_off_o = lba_i*2048 + index.
- R6: cmd_i = 3 is illegal. The chunk is ended with illegal_o, no request is issued, status_o becomes 0x41 (ready bit 6, error bit 0), irq_o rises and active_o clears.
- R7: A completion with xfer_err_i set pulses dma_err_o and chunk_end_o. It sets status_o to 0x41, raises irq_o and clears active_o.
- R8: A completion without error ends the chunk. If the count is then zero or below, the block also sets status_o to 0x50 (bit 6 ready, bit 4 seek-complete), raises irq_o and clears active_o. Otherwise irq_o stays low.
- R9: A chunk offered while active with a count already at zero or below finishes the command as in R8, without a request.
- R10: A zero-length chunk while active ends the chunk only: no request, no irq_o, and active_o stays 1.
- R11: An optical command with block_i = 0 answers a nonzero chunk with copy_o and copy_len_o = min(count, length). It then finishes with status 0x50, irq_o and chunk_end_o.
- R12: irq_o stays high until status_rd_i. When a raise and a read fall in the same cycle, the raise wins.
- R13: Chunks offered while a request awaits completion are ignored: no request, no wait_o, no chunk_end_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm a new command |
| optical_i | input | 1 | 1 = optical drive, 0 = disk |
| block_i | input | 1 | Optical command is block-based |
| cmd_i | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| nsect_i | input | SECT_W | Sector count for a disk command |
| pkt_bytes_i | input | PKT_W | Byte count for an optical command |
| cur_sector_i | input | LBA_W | Current disk sector |
| lba_i | input | LBA_W | Optical logical block |
| chunk_valid_i | input | 1 | Channel offers a chunk |
| chunk_len_i | input | LEN_W | Length of the offered chunk |
| xfer_done_i | input | 1 | Aligner finished the issued request |
| xfer_err_i | input | 1 | Completion carries an error |
| status_rd_i | input | 1 | Host reads the status byte |
| kick_o | output | 1 | Pulse: start the DMA channel |
| active_o | output | 1 | Command armed |
| req_o | output | 1 | Pulse: request to the aligner |
| req_kind_o | output | 2 | Request kind, same coding as cmd_i |
| req_off_o | output | LBA_W+12 | Request byte offset |
| req_len_o | output | LEN_W | Request byte length |
| copy_o | output | 1 | Pulse: direct copy |
| copy_len_o | output | LEN_W | Direct copy length |
| wait_o | output | 1 | Pulse: chunk parked, channel must restart |
| chunk_end_o | output | 1 | Pulse: current chunk done |
| dma_err_o | output | 1 | Pulse: DMA error |
| illegal_o | output | 1 | Pulse: illegal command code |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt level |

## Verification
A finishing completion and a host status read can fall in the same cycle, and they pull irq_o in opposite directions. The bench drives status_rd_i together with the xfer_done_i that consumes the last bytes of a command. One cycle later it expects irq_o still high with status 0x50. A later lone read must then drop irq_o. A chunk offered during the completion wait is a second overlap: the bench checks that this chunk produces no request, no wait and no chunk end.

// File: rtl/ide_seq_pkg.sv
`timescale 1ns/1ps
package ide_seq_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_TRIM  = 2'd2,
        K_BAD   = 2'd3
    } req_kind_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } seq_state_e;

    localparam logic [7:0] ST_BUSY  = 8'h80;
    localparam logic [7:0] ST_DONE  = 8'h50;
    localparam logic [7:0] ST_FAULT = 8'h41;

    function automatic int unsigned size_width(input int unsigned sect_w, input int unsigned pkt_w);
        return (sect_w + 9 > pkt_w) ? sect_w + 9 : pkt_w;
    endfunction
endpackage

// File: rtl/ide_seq_count.sv
`timescale 1ns/1ps
module ide_seq_count
    import ide_seq_pkg::*;
#(
    parameter int unsigned SECT_W = 8,
    parameter int unsigned PKT_W  = 16,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned REM_W  = size_width(SECT_W, PKT_W) + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    optical_i,
    input  logic [SECT_W-1:0]       nsect_i,
    input  logic [PKT_W-1:0]        pkt_i,
    input  logic                    adv_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic signed [REM_W-1:0] rem_o,
    output logic [REM_W-1:0]        idx_o,
    output logic                    rem_le0_o
);
    logic signed [REM_W-1:0] rem_q;
    logic [REM_W-1:0]        idx_q;
    logic [REM_W-1:0]        load_val;

    always_comb begin
        if (optical_i) load_val = REM_W'(pkt_i);
        else           load_val = REM_W'(nsect_i) << 9;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            rem_q <= signed'(load_val);
            idx_q <= '0;
        end else if (adv_i) begin
            rem_q <= rem_q - signed'(REM_W'(len_i));
            idx_q <= idx_q + REM_W'(len_i);
        end
    end

    assign rem_o     = rem_q;
    assign idx_o     = idx_q;
    assign rem_le0_o = (rem_q <= 0);
endmodule

// File: rtl/ide_seq_offset.sv
`timescale 1ns/1ps
module ide_seq_offset #(
    parameter int unsigned LBA_W = 24,
    parameter int unsigned IDX_W = 19,
    parameter int unsigned OFF_W = LBA_W + 12
) (
    input  logic             optical_i,
    input  logic [LBA_W-1:0] sector_i,
    input  logic [LBA_W-1:0] lba_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [OFF_W-1:0] off_o
);
    localparam int unsigned DISK_SH = 9;
    localparam int unsigned OPT_SH  = 11;

    always_comb begin
        if (optical_i) off_o = (OFF_W'(lba_i) << OPT_SH) + OFF_W'(idx_i);
        else           off_o = (OFF_W'(sector_i) << DISK_SH) + OFF_W'(idx_i);
    end
endmodule

// File: rtl/ide_seq_stat.sv
`timescale 1ns/1ps
module ide_seq_stat
    import ide_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_i,
    input  logic       raise_i,
    input  logic [7:0] raise_val_i,
    input  logic       rd_i,
    output logic [7:0] status_o,
    output logic       irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            if (raise_i)    status_o <= raise_val_i;
            else if (arm_i) status_o <= ST_BUSY;
            if (raise_i)    irq_o <= 1'b1;
            else if (rd_i)  irq_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ide_xfer_seq.sv
`timescale 1ns/1ps
module ide_xfer_seq
    import ide_seq_pkg::*;
#(
    parameter int unsigned SECT_W = 8,
    parameter int unsigned PKT_W  = 16,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned LBA_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              optical_i,
    input  logic              block_i,
    input  logic [1:0]        cmd_i,
    input  logic [SECT_W-1:0] nsect_i,
    input  logic [PKT_W-1:0]  pkt_bytes_i,
    input  logic [LBA_W-1:0]  cur_sector_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic              chunk_valid_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    input  logic              status_rd_i,
    output logic              kick_o,
    output logic              active_o,
    output logic              req_o,
    output logic [1:0]        req_kind_o,
    output logic [LBA_W+11:0] req_off_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic              copy_o,
    output logic [LEN_W-1:0]  copy_len_o,
    output logic              wait_o,
    output logic              chunk_end_o,
    output logic              dma_err_o,
    output logic              illegal_o,
    output logic [7:0]        status_o,
    output logic              irq_o
);
    localparam int unsigned REM_W = size_width(SECT_W, PKT_W) + 2;
    localparam int unsigned OFF_W = LBA_W + 12;

    seq_state_e              state_q;
    logic                    active_q;
    logic signed [REM_W-1:0] rem;
    logic [REM_W-1:0]        idx;
    logic                    rem_le0;
    logic [OFF_W-1:0]        off;

    logic offer, issue, bad_cmd, direct, finish, fault;
    logic [LEN_W-1:0] cp_len;

    assign offer   = chunk_valid_i && (state_q == S_IDLE) && !start_i;
    assign bad_cmd = (cmd_i == 2'(K_BAD));
    assign direct  = optical_i && !block_i;
    assign issue   = offer && active_q && !rem_le0 && (chunk_len_i != '0)
                     && !direct && !bad_cmd;

    always_comb begin
        if (rem < signed'(REM_W'(chunk_len_i))) cp_len = LEN_W'(rem);
        else                                   cp_len = chunk_len_i;
    end

    always_comb begin
        finish = 1'b0;
        fault  = 1'b0;
        if (offer && active_q) begin
            if (rem_le0) finish = 1'b1;
            else if (chunk_len_i != '0) begin
                if (direct)       finish = 1'b1;
                else if (bad_cmd) fault  = 1'b1;
            end
        end
        if (state_q == S_WAIT && xfer_done_i) begin
            if (xfer_err_i)   fault  = 1'b1;
            else if (rem_le0) finish = 1'b1;
        end
    end

    ide_seq_count #(.SECT_W(SECT_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .REM_W(REM_W)) u_cnt (
        .clk(clk), .rst(rst), .load_i(start_i), .optical_i(optical_i),
        .nsect_i(nsect_i), .pkt_i(pkt_bytes_i), .adv_i(issue), .len_i(chunk_len_i),
        .rem_o(rem), .idx_o(idx), .rem_le0_o(rem_le0)
    );

    ide_seq_offset #(.LBA_W(LBA_W), .IDX_W(REM_W), .OFF_W(OFF_W)) u_off (
        .optical_i(optical_i), .sector_i(cur_sector_i), .lba_i(lba_i),
        .idx_i(idx), .off_o(off)
    );

    ide_seq_stat u_stat (
        .clk(clk), .rst(rst), .arm_i(start_i), .raise_i(finish || fault),
        .raise_val_i(fault ? ST_FAULT : ST_DONE), .rd_i(status_rd_i),
        .status_o(status_o), .irq_o(irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            active_q    <= 1'b0;
            kick_o      <= 1'b0;
            req_o       <= 1'b0;
            req_kind_o  <= '0;
            req_off_o   <= '0;
            req_len_o   <= '0;
            copy_o      <= 1'b0;
            copy_len_o  <= '0;
            wait_o      <= 1'b0;
            chunk_end_o <= 1'b0;
            dma_err_o   <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            kick_o      <= start_i;
            req_o       <= issue;
            copy_o      <= 1'b0;
            wait_o      <= 1'b0;
            chunk_end_o <= 1'b0;
            dma_err_o   <= 1'b0;
            illegal_o   <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                state_q  <= S_IDLE;
            end else if (finish || fault) begin
                active_q <= 1'b0;
            end
            if (issue) begin
                req_kind_o <= cmd_i;
                req_off_o  <= off;
                req_len_o  <= chunk_len_i;
                state_q    <= S_WAIT;
            end
            if (offer) begin
                if (!active_q) begin
                    wait_o <= 1'b1;
                end else if (!issue) begin
                    chunk_end_o <= 1'b1;
                    if (!rem_le0 && chunk_len_i != '0) begin
                        if (direct) begin
                            copy_o     <= 1'b1;
                            copy_len_o <= cp_len;
                        end else begin
                            illegal_o <= 1'b1;
                        end
                    end
                end
            end
            if (state_q == S_WAIT && xfer_done_i && !start_i) begin
                state_q     <= S_IDLE;
                chunk_end_o <= 1'b1;
                dma_err_o   <= xfer_err_i;
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/ide_xfer_seq_chk.sv
`timescale 1ns/1ps
module ide_xfer_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       status_rd_i,
    input logic       kick_o,
    input logic       active_o,
    input logic       req_o,
    input logic [15:0] req_len_o,
    input logic       wait_o,
    input logic       chunk_end_o,
    input logic       dma_err_o,
    input logic       illegal_o,
    input logic [7:0] status_o,
    input logic       irq_o
);
    // R2: arming is seen one cycle after start
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (kick_o && active_o));
    // R3: parked chunk never ends the chunk
    p_park_r3: assert property (@(posedge clk) disable iff (rst)
        wait_o |-> !chunk_end_o && !req_o);
    // R10: a request never carries a zero length
    p_len_r10: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (req_len_o != '0));
    // R7: a DMA error always ends the chunk and faults the status
    p_err_r7: assert property (@(posedge clk) disable iff (rst)
        dma_err_o |-> chunk_end_o && status_o == 8'h41);
    // R6: illegal code ends the chunk
    p_bad_r6: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> chunk_end_o && !active_o);
    // R12: irq only falls after a status read
    p_irq_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(status_rd_i));
    // R8: a rising irq comes with the ready bit
    p_rdy_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> status_o[6]);
endmodule

bind ide_xfer_seq ide_xfer_seq_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .status_rd_i(status_rd_i),
    .kick_o(kick_o), .active_o(active_o), .req_o(req_o), .req_len_o(req_len_o[15:0]),
    .wait_o(wait_o), .chunk_end_o(chunk_end_o), .dma_err_o(dma_err_o),
    .illegal_o(illegal_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/sim_ide_xfer_seq.sv
`timescale 1ns/1ps
module sim_ide_xfer_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, optical_i = 0, block_i = 0;
    logic [1:0] cmd_i = 0;
    logic [7:0] nsect_i = 0;
    logic [15:0] pkt_bytes_i = 0;
    logic [23:0] cur_sector_i = 24'd10, lba_i = 24'd3;
    logic chunk_valid_i = 0;
    logic [15:0] chunk_len_i = 0;
    logic xfer_done_i = 0, xfer_err_i = 0, status_rd_i = 0;
    logic kick_o, active_o, req_o, copy_o, wait_o, chunk_end_o, dma_err_o, illegal_o, irq_o;
    logic [1:0] req_kind_o;
    logic [35:0] req_off_o;
    logic [15:0] req_len_o, copy_len_o;
    logic [7:0] status_o;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    ide_xfer_seq u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        start_i = 0; chunk_valid_i = 0; xfer_done_i = 0; xfer_err_i = 0; status_rd_i = 0;
    endtask

    task automatic arm(input bit opt, input bit blk, input int ns, input int pk, input int c);
        optical_i = opt; block_i = blk; nsect_i = 8'(ns); pkt_bytes_i = 16'(pk); cmd_i = 2'(c);
        start_i = 1; tick();
        chk(kick_o && active_o, "R2 kick/active", {kick_o, active_o}, 3);
        chk(status_o == 8'h80, "R2 busy status", status_o, 8'h80);
    endtask

    task automatic offer(input int len);
        chunk_valid_i = 1; chunk_len_i = 16'(len); tick();
    endtask

    task automatic done(input bit err, input bit rd);
        xfer_done_i = 1; xfer_err_i = err; status_rd_i = rd; tick();
    endtask

    task automatic clear_irq();
        status_rd_i = 1; tick();
        chk(!irq_o, "R12 read clears irq", irq_o, 0);
    endtask

    initial begin
        int lens[3] = '{256, 512, 768};
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        // R1
        chk(status_o == 0 && !irq_o && !active_o && !req_o && !wait_o && !chunk_end_o,
            "R1 reset state", {status_o, irq_o, active_o}, 0);
        // R3: not armed
        offer(512);
        chk(wait_o && !chunk_end_o && !req_o, "R3 park when inactive", {wait_o, chunk_end_o, req_o}, 4);

        // R4/R8 disk sweep
        for (int ns = 1; ns <= 3; ns++) begin
            for (int li = 0; li < 3; li++) begin
                for (int c = 0; c < 3; c++) begin
                    int rem = ns * 512;
                    int idx = 0;
                    arm(0, 0, ns, 0, c);
                    while (rem > 0) begin
                        offer(lens[li]);
                        chk(req_o && req_kind_o == 2'(c), "R4 request kind", req_kind_o, c);
                        chk(req_off_o == 36'(10 * 512 + idx), "R4 disk offset", req_off_o, 10 * 512 + idx);
                        chk(req_len_o == 16'(lens[li]), "R4 request length", req_len_o, lens[li]);
                        rem -= lens[li]; idx += lens[li];
                        done(0, 0);
                        chk(chunk_end_o, "R8 chunk end", chunk_end_o, 1);
                        if (rem <= 0) begin
                            chk(irq_o && status_o == 8'h50 && !active_o, "R8 finish", {irq_o, status_o}, 9'h150);
                        end else begin
                            chk(!irq_o && active_o, "R8 no early irq", irq_o, 0);
                        end
                    end
                    clear_irq();
                end
            end
        end

        // R5 optical block offsets
        arm(1, 1, 0, 4096, 0);
        offer(2048);
        chk(req_o && req_off_o == 36'(3 * 2048), "R5 optical offset", req_off_o, 3 * 2048);
        // R13 chunk during completion wait
        offer(2048);
        chk(!req_o && !wait_o && !chunk_end_o, "R13 ignored while waiting", {req_o, wait_o, chunk_end_o}, 0);
        done(0, 0);
        offer(2048);
        chk(req_off_o == 36'(3 * 2048 + 2048), "R5 optical offset advanced", req_off_o, 3 * 2048 + 2048);
        // R12 raise and read together
        done(0, 1);
        chk(irq_o && status_o == 8'h50, "R12 raise beats read", irq_o, 1);
        clear_irq();

        // R9 count already zero
        arm(0, 0, 0, 0, 0);
        offer(512);
        chk(!req_o && chunk_end_o && irq_o && status_o == 8'h50 && !active_o, "R9 finish on arrival", status_o, 8'h50);
        clear_irq();

        // R10 zero-length chunk
        arm(0, 0, 2, 0, 1);
        offer(0);
        chk(chunk_end_o && !req_o && !irq_o && active_o, "R10 zero length", {chunk_end_o, req_o, irq_o, active_o}, 9);
        // R7 error completion
        offer(512);
        done(1, 0);
        chk(dma_err_o && chunk_end_o && status_o == 8'h41 && irq_o && !active_o, "R7 error", status_o, 8'h41);
        clear_irq();

        // R6 illegal code
        arm(0, 0, 2, 0, 3);
        offer(512);
        chk(illegal_o && chunk_end_o && !req_o && status_o == 8'h41 && irq_o, "R6 illegal", status_o, 8'h41);
        clear_irq();

        // R11 direct copy
        arm(1, 0, 0, 100, 0);
        offer(512);
        chk(copy_o && copy_len_o == 100, "R11 copy bounded by count", copy_len_o, 100);
        chk(chunk_end_o && irq_o && status_o == 8'h50 && !req_o, "R11 completes", status_o, 8'h50);
        clear_irq();
        arm(1, 0, 0, 600, 0);
        offer(200);
        chk(copy_o && copy_len_o == 200, "R11 copy bounded by chunk", copy_len_o, 200);
        clear_irq();
        // R3 again after completion
        offer(64);
        chk(wait_o && !chunk_end_o, "R3 park after finish", wait_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule